// File: doc/BRIEF.md
# Feedback and Reference Divider Pair with Single-Cycle Add/Drop

This block holds the two counters that set the ratio of a frequency synthesizer loop. The feedback counter counts oscillator cycles and the reference counter counts reference cycles. Each counter issues one compare pulse at the end of every division period, and a phase detector that sits outside this block consumes those pulses. In lock, the output frequency equals the reference frequency times M divided by R. The design uses a single clock and takes the two counted clocks as enable strobes: `outEn` for the oscillator and `refEn` for the reference. This keeps the counting logic fully synchronous.

A rising edge on the add request makes one feedback division period last M+1 counts. A rising edge on the drop request makes one period last M−1 counts. In either case the loop inserts or removes exactly one output cycle relative to the reference. The adjusted period is the first one that starts after the request is captured. Only one correction is allowed per reference period. Request edges that arrive while a correction is still outstanding are discarded, and each discarded edge is reported by a one-cycle status pulse. A secondary output strobe divides the oscillator strobe by four or passes it through unchanged.

Top module: `fbdiv_top`

## Requirements
- R1: While `rstN` is low, `fbPulse`, `refPulse`, `postTick` and `rejectPulse` are 0. The first feedback period after reset lasts 32 `outEn` counts, and the first reference period lasts 1 `refEn` count, whatever the configuration inputs hold.
- R2: With no request pending, successive `fbPulse` outputs are spaced exactly `cfgM` `outEn` counts apart. Each pulse is one clock wide and appears the clock after the terminal `outEn`.
- R3: Successive `refPulse` outputs are spaced exactly `cfgR` `refEn` counts apart.
- R4: A rising edge on `addReq` makes exactly one feedback period last `cfgM`+1 counts. That is the period starting at the first feedback terminal after the edge is captured.
- R5: A rising edge on `dropReq` makes exactly one feedback period last `cfgM`−1 counts, chosen in the same way as in R4.
- R6: A change of `cfgM` takes effect only at a feedback terminal. The period already running keeps its old length.
- R7: A change of `cfgR` takes effect only at a reference terminal. The period already running keeps its old length.
- R8: A request edge that arrives while an earlier correction is captured but not yet applied is discarded. No second period is altered, and `rejectPulse` is high for one clock.
- R9: After a correction has been applied, further request edges are discarded with a `rejectPulse` until the next reference terminal. An edge after that terminal is accepted.
- R10: Add and drop edges in the same clock cancel. No period is altered and no `rejectPulse` is raised.
- R11: Requests are edge-triggered. Holding `addReq` high for many periods alters exactly one period.
- R12: With `quarterSel` = 1, `postTick` pulses once per 4 `outEn` counts. With `quarterSel` = 0, it pulses once per `outEn` count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| outEn | input | 1 | One strobe per oscillator cycle |
| refEn | input | 1 | One strobe per reference cycle |
| cfgM | input | 10 | Feedback ratio M (4 to 1023) |
| cfgR | input | 9 | Reference ratio R (1 to 511) |
| quarterSel | input | 1 | 1: secondary strobe divides by 4; 0: divides by 1 |
| addReq | input | 1 | Add-one-cycle request, edge sensitive |
| dropReq | input | 1 | Drop-one-cycle request, edge sensitive |
| fbPulse | output | 1 | Feedback compare pulse |
| refPulse | output | 1 | Reference compare pulse |
| postTick | output | 1 | Secondary divided output strobe |
| rejectPulse | output | 1 | A request edge was discarded |

## Verification
Faults in the terminal compare or the limit register show up within one division period as a spacing of `fbPulse` or `refPulse` that differs from the configured ratio. A fault in the correction state machine changes the number of odd-length periods: it yields none, two, or a stretch where a shrink was asked for. This shows within two feedback periods of the request, or within one reference period when the lockout is involved. A wrong reject decision changes the count of `rejectPulse` on the clock after the offending edge.

// File: rtl/fbdiv_pkg.sv
`timescale 1ns/1ps
package fbdiv_pkg;
  // adjustment strobes from control to datapath
  typedef struct packed {
    logic adjUp;
    logic adjDn;
  } fbAdj_t;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_PEND = 2'd1,
    CS_HOLD = 2'd2
  } corrState_t;
endpackage

// File: rtl/fbdiv_modulo.sv
`timescale 1ns/1ps
module fbdiv_modulo #(
  parameter int CW      = 10,
  parameter int RST_LIM = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          en,
  input  logic [CW:0]   nextLim,
  output logic          term,
  output logic          pulse
);
  localparam logic [CW:0] ONE = (CW+1)'(1);

  logic [CW-1:0] cnt;
  logic [CW:0]   lim;

  assign term = en && ({1'b0, cnt} == (lim - ONE));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      lim   <= (CW+1)'(RST_LIM);
      pulse <= 1'b0;
    end else begin
      pulse <= term;
      if (term) begin
        cnt <= '0;
        lim <= nextLim;
      end else if (en) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fbdiv_datapath.sv
`timescale 1ns/1ps
module fbdiv_datapath
  import fbdiv_pkg::*;
#(
  parameter int M_W      = 10,
  parameter int R_W      = 9,
  parameter int M_DEF    = 32,
  parameter int R_DEF    = 1,
  parameter int POST_DIV = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           outEn,
  input  logic           refEn,
  input  logic [M_W-1:0] cfgM,
  input  logic [R_W-1:0] cfgR,
  input  logic           quarterSel,
  input  fbAdj_t         adj,
  output logic           mTerm,
  output logic           rTerm,
  output logic           fbPulse,
  output logic           refPulse,
  output logic           postTick
);
  localparam int PW = (POST_DIV > 1) ? $clog2(POST_DIV) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(POST_DIV - 1);

  logic [M_W:0] mBase, mNext;
  logic [R_W:0] rNext;

  // limit for the period that starts at the next feedback terminal
  always_comb begin
    mBase = {1'b0, cfgM};
    if (adj.adjUp)      mNext = mBase + 1'b1;
    else if (adj.adjDn) mNext = mBase - 1'b1;
    else                mNext = mBase;
  end

  assign rNext = {1'b0, cfgR};

  fbdiv_modulo #(.CW(M_W), .RST_LIM(M_DEF)) u_mDiv (
    .clk(clk), .rstN(rstN), .en(outEn), .nextLim(mNext),
    .term(mTerm), .pulse(fbPulse)
  );

  fbdiv_modulo #(.CW(R_W), .RST_LIM(R_DEF)) u_rDiv (
    .clk(clk), .rstN(rstN), .en(refEn), .nextLim(rNext),
    .term(rTerm), .pulse(refPulse)
  );

  // secondary post divider
  logic [PW-1:0] pCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pCnt     <= '0;
      postTick <= 1'b0;
    end else begin
      postTick <= outEn && (!quarterSel || (pCnt == P_LAST));
      if (outEn) pCnt <= (pCnt == P_LAST) ? '0 : pCnt + 1'b1;
    end
  end
endmodule

// File: rtl/fbdiv_ctrl.sv
`timescale 1ns/1ps
module fbdiv_ctrl
  import fbdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   addReq,
  input  logic   dropReq,
  input  logic   mTerm,
  input  logic   rTerm,
  output fbAdj_t adj,
  output logic   addEdge,
  output logic   dropEdge,
  output logic   rejectPulse
);
  logic       addPrev, dropPrev, pendUp;
  corrState_t st;

  assign addEdge  = addReq  && !addPrev;
  assign dropEdge = dropReq && !dropPrev;

  always_comb begin
    adj.adjUp = (st == CS_PEND) &&  pendUp;
    adj.adjDn = (st == CS_PEND) && !pendUp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addPrev     <= 1'b0;
      dropPrev    <= 1'b0;
      pendUp      <= 1'b0;
      rejectPulse <= 1'b0;
      st          <= CS_IDLE;
    end else begin
      addPrev     <= addReq;
      dropPrev    <= dropReq;
      rejectPulse <= 1'b0;
      case (st)
        CS_IDLE: begin
          // simultaneous edges cancel
          if (addEdge ^ dropEdge) begin
            st     <= CS_PEND;
            pendUp <= addEdge;
          end
        end
        CS_PEND: begin
          if (addEdge || dropEdge) rejectPulse <= 1'b1;
          if (mTerm) st <= CS_HOLD;
        end
        CS_HOLD: begin
          if (addEdge || dropEdge) rejectPulse <= 1'b1;
          if (rTerm) st <= CS_IDLE;
        end
        default: st <= CS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fbdiv_top.sv
`timescale 1ns/1ps
module fbdiv_top
  import fbdiv_pkg::*;
#(
  parameter int M_W      = 10,
  parameter int R_W      = 9,
  parameter int M_DEF    = 32,
  parameter int R_DEF    = 1,
  parameter int POST_DIV = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           outEn,
  input  logic           refEn,
  input  logic [M_W-1:0] cfgM,
  input  logic [R_W-1:0] cfgR,
  input  logic           quarterSel,
  input  logic           addReq,
  input  logic           dropReq,
  output logic           fbPulse,
  output logic           refPulse,
  output logic           postTick,
  output logic           rejectPulse
);
  fbAdj_t adj;
  logic   mTerm, rTerm, addEdge, dropEdge;

  fbdiv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addReq(addReq), .dropReq(dropReq),
    .mTerm(mTerm), .rTerm(rTerm), .adj(adj),
    .addEdge(addEdge), .dropEdge(dropEdge), .rejectPulse(rejectPulse)
  );

  fbdiv_datapath #(
    .M_W(M_W), .R_W(R_W), .M_DEF(M_DEF), .R_DEF(R_DEF), .POST_DIV(POST_DIV)
  ) u_dp (
    .clk(clk), .rstN(rstN), .outEn(outEn), .refEn(refEn),
    .cfgM(cfgM), .cfgR(cfgR), .quarterSel(quarterSel), .adj(adj),
    .mTerm(mTerm), .rTerm(rTerm), .fbPulse(fbPulse),
    .refPulse(refPulse), .postTick(postTick)
  );
endmodule

// File: rtl/fbdiv_chk.sv
`timescale 1ns/1ps
module fbdiv_chk (
  input logic clk,
  input logic rstN,
  input logic outEn,
  input logic refEn,
  input logic fbPulse,
  input logic refPulse,
  input logic postTick,
  input logic rejectPulse,
  input logic addEdge,
  input logic dropEdge
);
  AST_FB_ONE_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    fbPulse |=> !fbPulse); // R2

  AST_FB_AFTER_OUT: assert property (@(posedge clk) disable iff (!rstN)
    fbPulse |-> $past(outEn)); // R2

  AST_REF_AFTER_REF: assert property (@(posedge clk) disable iff (!rstN)
    refPulse |-> $past(refEn)); // R3

  AST_POST_AFTER_OUT: assert property (@(posedge clk) disable iff (!rstN)
    postTick |-> $past(outEn)); // R12

  AST_REJECT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    rejectPulse |-> $past(addEdge || dropEdge)); // R8
endmodule

bind fbdiv_top fbdiv_chk u_chk (
  .clk(clk), .rstN(rstN), .outEn(outEn), .refEn(refEn),
  .fbPulse(fbPulse), .refPulse(refPulse), .postTick(postTick),
  .rejectPulse(rejectPulse), .addEdge(addEdge), .dropEdge(dropEdge)
);

// File: tb/test_fbdiv_top.sv
`timescale 1ns/1ps
module test_fbdiv_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       outEn = 1'b1;
  logic       refEn = 1'b1;
  logic [9:0] cfgM = 10'd8;
  logic [8:0] cfgR = 9'd8;
  logic       quarterSel = 1'b0;
  logic       addReq = 1'b0;
  logic       dropReq = 1'b0;
  logic       fbPulse, refPulse, postTick, rejectPulse;

  int total = 0;
  int bad = 0;
  int outCount = 0, refCount = 0, fbMark = 0, refMark = 0;
  int gapBuf[64];
  int refBuf[64];
  int gapN = 0, refN = 0, rejN = 0, postN = 0;

  always #2 clk = ~clk;

  fbdiv_top i_fbdiv_top (
    .clk(clk), .rstN(rstN), .outEn(outEn), .refEn(refEn),
    .cfgM(cfgM), .cfgR(cfgR), .quarterSel(quarterSel),
    .addReq(addReq), .dropReq(dropReq),
    .fbPulse(fbPulse), .refPulse(refPulse),
    .postTick(postTick), .rejectPulse(rejectPulse)
  );

  // monitor: count strobes at the edge, read registered outputs just after
  always @(posedge clk) begin
    if (!rstN) begin
      outCount = 0; refCount = 0; fbMark = 0; refMark = 0;
    end else begin
      if (outEn) outCount++;
      if (refEn) refCount++;
      #1;
      if (fbPulse) begin
        if (gapN < 64) gapBuf[gapN] = outCount - fbMark;
        gapN++;
        fbMark = outCount;
      end
      if (refPulse) begin
        if (refN < 64) refBuf[refN] = refCount - refMark;
        refN++;
        refMark = refCount;
      end
      if (rejectPulse) rejN++;
      if (postTick) postN++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearLog();
    gapN = 0; refN = 0; rejN = 0; postN = 0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitFb();
    do @(negedge clk); while (!fbPulse);
  endtask

  task automatic waitRef();
    do @(negedge clk); while (!refPulse);
  endtask

  task automatic pulseReq(input bit doAdd, input bit doDrop, input int len);
    @(negedge clk);
    addReq = doAdd; dropReq = doDrop;
    repeat (len) @(negedge clk);
    addReq = 1'b0; dropReq = 1'b0;
  endtask

  // all gaps equal m except nOdd of them equal m+delta
  task automatic evalGaps(input int m, input int delta, input int nOdd, input string req);
    int odd = 0;
    int wrong = 0;
    for (int i = 0; i < gapN && i < 64; i++) begin
      if (gapBuf[i] == m) ;
      else if (delta != 0 && gapBuf[i] == m + delta) odd++;
      else wrong++;
    end
    check(gapN >= 3, req, gapN, 3);
    check(wrong == 0 && odd == nOdd, req, odd, nOdd);
  endtask

  task automatic tReset();
    rstN = 1'b0;
    cfgM = 10'd8; cfgR = 9'd8;
    waitCyc(3);
    check(!fbPulse && !refPulse && !postTick && !rejectPulse, "R1 reset outputs",
          {fbPulse, refPulse, postTick, rejectPulse}, 0);
    clearLog();
    rstN = 1'b1;
    waitCyc(60);
    check(gapN >= 2 && gapBuf[0] == 32, "R1 first feedback period", gapBuf[0], 32);
    check(refN >= 2 && refBuf[0] == 1, "R1 first reference period", refBuf[0], 1);
  endtask

  task automatic tSteady();
    clearLog();
    waitCyc(50);
    evalGaps(8, 0, 0, "R2 steady ratio");
    check(refN >= 3 && refBuf[1] == 8 && refBuf[2] == 8, "R3 reference ratio", refBuf[1], 8);
  endtask

  task automatic tChangeM();
    waitFb();
    clearLog();
    cfgM = 10'd12;
    waitCyc(40);
    check(gapBuf[0] == 8, "R6 running period keeps old M", gapBuf[0], 8);
    check(gapBuf[1] == 12, "R6 new M after terminal", gapBuf[1], 12);
    cfgM = 10'd8;
    waitCyc(30);
  endtask

  task automatic tChangeR();
    waitRef();
    clearLog();
    cfgR = 9'd16;
    waitCyc(40);
    check(refBuf[0] == 8, "R7 running period keeps old R", refBuf[0], 8);
    check(refBuf[1] == 16, "R7 new R after terminal", refBuf[1], 16);
    cfgR = 9'd8;
    waitCyc(40);
  endtask

  task automatic tAdd();
    clearLog();
    pulseReq(1'b1, 1'b0, 3);
    waitCyc(60);
    evalGaps(8, 1, 1, "R4 add one cycle");
    check(rejN == 0, "R4 no reject", rejN, 0);
  endtask

  task automatic tDrop();
    waitCyc(20);
    clearLog();
    pulseReq(1'b0, 1'b1, 3);
    waitCyc(60);
    evalGaps(8, -1, 1, "R5 drop one cycle");
    check(rejN == 0, "R5 no reject", rejN, 0);
  endtask

  task automatic tPendingReject();
    waitCyc(20);
    waitFb();
    clearLog();
    pulseReq(1'b1, 1'b0, 2);
    pulseReq(1'b1, 1'b0, 2);
    waitCyc(60);
    evalGaps(8, 1, 1, "R8 second edge discarded");
    check(rejN == 1, "R8 reject flagged", rejN, 1);
  endtask

  task automatic tLockout();
    waitCyc(20);
    cfgR = 9'd64;
    waitRef();
    waitRef();
    clearLog();
    pulseReq(1'b1, 1'b0, 2);
    waitFb();
    pulseReq(1'b0, 1'b1, 2);
    waitRef();
    pulseReq(1'b1, 1'b0, 2);
    waitCyc(40);
    evalGaps(8, 1, 2, "R9 lockout then accept");
    check(rejN == 1, "R9 lockout reject", rejN, 1);
    cfgR = 9'd8;
    waitCyc(140);
  endtask

  task automatic tCancel();
    waitFb();
    clearLog();
    pulseReq(1'b1, 1'b1, 3);
    waitCyc(50);
    evalGaps(8, 0, 0, "R10 add and drop cancel");
    check(rejN == 0, "R10 no reject", rejN, 0);
  endtask

  task automatic tLevel();
    waitCyc(20);
    clearLog();
    pulseReq(1'b1, 1'b0, 80);
    waitCyc(30);
    evalGaps(8, 1, 1, "R11 level held");
    check(rejN == 0, "R11 no reject", rejN, 0);
  endtask

  task automatic tPost();
    quarterSel = 1'b1;
    waitCyc(8);
    postN = 0;
    waitCyc(40);
    check(postN == 10, "R12 divide by four", postN, 10);
    quarterSel = 1'b0;
    waitCyc(4);
    postN = 0;
    waitCyc(40);
    check(postN == 40, "R12 divide by one", postN, 40);
  endtask

  initial begin
    tReset();
    tSteady();
    tChangeM();
    tChangeR();
    tAdd();
    tDrop();
    tPendingReject();
    tLockout();
    tCancel();
    tLevel();
    tPost();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule